// File: doc/BRIEF.md
# High-Side Switch Fault Supervisor

This block is the digital protection controller for a multi-channel smart high-side power switch. Each channel turns on when its direct input pin or its register enable bit is high. Comparator outputs from the analog front end can force the channel's gate off: over-temperature, over-current and open-load per channel, plus over-voltage and under-voltage on the shared supply. Each fault class has its own recovery rule. Some faults release on their own. Some stay latched until the command goes low and then high again. Under-voltage latches only when the direct input is the source of the command.

A single active-low fault pin tells the host that any condition is present. A sticky status word records which faults were seen. The host reads that word by pulsing a read strobe, and the same strobe clears it. When the logic supply is lost, the status word and the register-side controls drop out. The channels then follow their direct pins, and every protection is enabled.

All inputs are plain synchronous control and status signals. There is no streaming data path, so the block has no valid/ready interface and exerts no back-pressure. A read is accepted in every cycle the strobe is high.

Top module: `hss_fault_supervisor`

## Requirements
- R1: After reset every `gate_en` bit is 0, `fault_n` is 1 and `rd_word` reads 0.
- R2: With no fault present, `gate_en[i]` equals `direct_in[i] | reg_on[i]` one clock after the command settles.
- R3: Over-temperature is acted on only while the gate is on. The gate goes off at the next clock and stays off while `over_temp[i]` is high. It turns back on one clock after the flag drops if the command is still high, and this cycle can repeat any number of times.
- R4: While `over_volt` is high and `ovp_off` is low, every gate is off, and gates recover one clock after the flag drops. With `ovp_off` high, the gates stay on, but the condition is still reported in the status word and on `fault_n`.
- R5: Under-voltage seen while `direct_in[i]` is high and `uvp_off` is low latches channel i off. The latch clears on a command low followed by a command high. `fault_n` stays low while the latch is set.
- R6: Under-voltage seen while `direct_in[i]` is low (register command only) does not latch. The gate recovers one clock after the flag drops.
- R7: With `uvp_off` high, under-voltage does not turn any gate off, and status bit 2N+N+1 (bit 3N+1) still reports it.
- R8: An open load is reported only when `gate_en[i]` is 0, `gate_low[i]` is 1 and `olp_off` is 0.
- R9: Over-current while the gate is on latches the channel off until the command goes low and then high. `fault_n` stays low while latched. Other channels are not affected.
- R10: `fault_n` goes low one clock after any condition or warning is present. It returns high one clock after all of them clear, except while an over-current or under-voltage latch is held.
- R11: Status layout: channel i uses bit 3i for over-temperature, 3i+1 for open load and 3i+2 for over-current. Bit 3N is over-voltage and bit 3N+1 is under-voltage. Bits are sticky. In a strobe cycle, `rd_word` shows the stored bits OR the faults present now, and the word clears at that clock. A fault still present sets its bit again at the following clock.
- R12: While `logic_pwr_ok` is 0, the following apply:
  - the status word is held clear and `rd_word` reads 0;
  - `reg_on` and the three protection-disable inputs are ignored;
  - each gate follows `direct_in` subject to full protection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| logic_pwr_ok | input | 1 | Logic supply within range; 0 drops register state |
| direct_in | input | NCH | Direct command pin per channel |
| reg_on | input | NCH | Register enable bit per channel |
| over_temp | input | NCH | Over-temperature comparator per channel |
| open_load | input | NCH | Open-load comparator per channel |
| gate_low | input | NCH | Gate voltage pulled low indication per channel |
| over_curr | input | NCH | Over-current trip (already time-qualified) per channel |
| over_volt | input | 1 | Supply over-voltage comparator |
| under_volt | input | 1 | Supply under-voltage comparator |
| ovp_off | input | 1 | Disable over-voltage shutdown |
| uvp_off | input | 1 | Disable under-voltage shutdown |
| olp_off | input | 1 | Disable open-load detection |
| rd_strobe | input | 1 | Status read strobe, clears the word |
| gate_en | output | NCH | Gate drive enable per channel |
| fault_n | output | 1 | Active-low fault summary |
| rd_word | output | 3*NCH+2 | Status word presented during a read |

## Verification
The assertions take for granted the following:
- every comparator input is already synchronous to `clk`;
- over-current trips arrive already time-qualified;
- `rst_n` is low at time zero.

The bench satisfies these by changing inputs only on the falling edge. It holds each pattern for several cycles before sampling, and it clears the status word with a read after each pattern settles, so no transition leftovers are compared. An exhaustive sweep covers every combination of command sources, over-voltage, open-load, gate-low and the two related disable bits on one channel. Directed sequences then drive the latch and recovery paths.

// File: rtl/hss_pkg.sv
package hss_pkg;
  localparam int FIELDS_PER_CH = 3;
  localparam int GLOBAL_BITS   = 2;
  localparam int HOT_POS       = 0;
  localparam int OPEN_POS      = 1;
  localparam int CURR_POS      = 2;

  typedef struct packed {
    logic curr;
    logic open;
    logic hot;
  } ch_flags_t;
endpackage

// File: rtl/hss_relatch.sv
module hss_relatch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic cmd,
  output logic held
);
  logic held_q, off_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      off_seen_q <= 1'b0;
    end else begin
      if (set)
        held_q <= 1'b1;
      else if (held_q && off_seen_q && cmd)
        held_q <= 1'b0;

      if (set || !held_q)
        off_seen_q <= 1'b0;
      else if (!cmd)
        off_seen_q <= 1'b1;
    end
  end

  assign held = held_q;

  // R5/R9: a held latch cannot release without an observed command low
  a_r9_hold_until_off: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && cmd && !off_seen_q) |=> held_q);
endmodule

// File: rtl/hss_channel.sv
module hss_channel
  import hss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd,
  input  logic      direct,
  input  logic      hot,
  input  logic      open,
  input  logic      gate_low,
  input  logic      curr,
  input  logic      vhigh,
  input  logic      vlow,
  input  logic      ovp_en,
  input  logic      uvp_en,
  input  logic      olp_en,
  output logic      gate,
  output ch_flags_t flags,
  output logic      alarm
);
  logic gate_q, hot_hold_q, hot_hold_d, hot_trip;
  logic curr_set, curr_held, vlow_set, vlow_held;
  logic vhigh_block, vlow_block, open_now, gate_d;

  assign hot_trip    = hot && gate_q;
  assign hot_hold_d  = hot && (hot_hold_q || hot_trip);
  assign curr_set    = curr && gate_q;
  assign vlow_set    = vlow && uvp_en && direct;
  assign vhigh_block = vhigh && ovp_en;
  assign vlow_block  = (vlow && uvp_en) || vlow_held;
  assign open_now    = open && olp_en && !gate_q && gate_low;

  hss_relatch u_curr_latch (
    .clk(clk), .rst_n(rst_n), .set(curr_set), .cmd(cmd), .held(curr_held)
  );

  hss_relatch u_vlow_latch (
    .clk(clk), .rst_n(rst_n), .set(vlow_set), .cmd(cmd), .held(vlow_held)
  );

  assign gate_d = cmd && !hot_hold_d && !vhigh_block && !vlow_block
                  && !curr_held && !curr_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q     <= 1'b0;
      hot_hold_q <= 1'b0;
    end else begin
      gate_q     <= gate_d;
      hot_hold_q <= hot_hold_d;
    end
  end

  assign gate       = gate_q;
  assign flags.hot  = hot_trip || hot_hold_q;
  assign flags.open = open_now;
  assign flags.curr = curr_set || curr_held;
  assign alarm      = flags.hot || open_now || flags.curr || vlow_held;

  // R2: the gate is never on unless the command was high at the last edge
  a_r2_gate_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> $past(cmd));
  // R3: a thermal hold and an on gate never coexist
  a_r3_hot_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    hot_hold_q |-> !gate_q);
  // R4: enabled over-voltage forces the gate off at the next edge
  a_r4_vhigh_off: assert property (@(posedge clk) disable iff (!rst_n)
    (vhigh && ovp_en) |=> !gate_q);
  // R9: a held over-current latch keeps the gate off
  a_r9_curr_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    curr_held |-> !gate_q);
endmodule

// File: rtl/hss_status.sv
module hss_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pwr_ok,
  input  logic         rd,
  input  logic [W-1:0] live,
  output logic [W-1:0] word
);
  logic [W-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= '0;
    else if (!pwr_ok || rd)
      stat_q <= '0;
    else
      stat_q <= stat_q | live;
  end

  assign word = pwr_ok ? (stat_q | live) : '0;

  // R11: a read or supply loss leaves the word empty after the edge
  a_r11_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd || !pwr_ok) |=> (stat_q == '0));
  // R11: without a read, stored bits never drop
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && !rd) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/hss_fault_supervisor.sv
module hss_fault_supervisor
  import hss_pkg::*;
#(
  parameter int NCH = 4,
  localparam int SW = NCH * FIELDS_PER_CH + GLOBAL_BITS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           logic_pwr_ok,
  input  logic [NCH-1:0] direct_in,
  input  logic [NCH-1:0] reg_on,
  input  logic [NCH-1:0] over_temp,
  input  logic [NCH-1:0] open_load,
  input  logic [NCH-1:0] gate_low,
  input  logic [NCH-1:0] over_curr,
  input  logic           over_volt,
  input  logic           under_volt,
  input  logic           ovp_off,
  input  logic           uvp_off,
  input  logic           olp_off,
  input  logic           rd_strobe,
  output logic [NCH-1:0] gate_en,
  output logic           fault_n,
  output logic [SW-1:0]  rd_word
);
  localparam int VHIGH_POS = NCH * FIELDS_PER_CH;
  localparam int VLOW_POS  = VHIGH_POS + 1;

  logic           ovp_en, uvp_en, olp_en;
  logic [NCH-1:0] ch_alarm;
  logic [SW-1:0]  live;
  logic           any_alarm, fault_n_q;

  assign ovp_en = !(ovp_off && logic_pwr_ok);
  assign uvp_en = !(uvp_off && logic_pwr_ok);
  assign olp_en = !(olp_off && logic_pwr_ok);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic      cmd_i;
    ch_flags_t fl_i;

    assign cmd_i = direct_in[i] || (reg_on[i] && logic_pwr_ok);

    hss_channel u_ch (
      .clk(clk), .rst_n(rst_n), .cmd(cmd_i), .direct(direct_in[i]),
      .hot(over_temp[i]), .open(open_load[i]), .gate_low(gate_low[i]),
      .curr(over_curr[i]), .vhigh(over_volt), .vlow(under_volt),
      .ovp_en(ovp_en), .uvp_en(uvp_en), .olp_en(olp_en),
      .gate(gate_en[i]), .flags(fl_i), .alarm(ch_alarm[i])
    );

    assign live[i*FIELDS_PER_CH + HOT_POS]  = fl_i.hot;
    assign live[i*FIELDS_PER_CH + OPEN_POS] = fl_i.open;
    assign live[i*FIELDS_PER_CH + CURR_POS] = fl_i.curr;
  end

  assign live[VHIGH_POS] = over_volt;
  assign live[VLOW_POS]  = under_volt;

  assign any_alarm = (|ch_alarm) || over_volt || under_volt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_n_q <= 1'b1;
    else        fault_n_q <= !any_alarm;
  end

  assign fault_n = fault_n_q;

  hss_status #(.W(SW)) u_status (
    .clk(clk), .rst_n(rst_n), .pwr_ok(logic_pwr_ok), .rd(rd_strobe),
    .live(live), .word(rd_word)
  );

  // R10: any supply-level condition pulls the fault pin low at the next edge
  a_r10_supply_fault_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (over_volt || under_volt) |=> !fault_n);
  // R12: without the logic supply a gate is on only after a high direct pin
  a_r12_direct_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!logic_pwr_ok && !direct_in[0]) |=> !gate_en[0]);
endmodule

// File: tb/tb_hss_fault_supervisor.sv
module tb_hss_fault_supervisor;
  localparam int NCH = 2;
  localparam int SW  = 3 * NCH + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr = 1'b1;
  logic [NCH-1:0] din = '0, ron = '0, hot = '0, opn = '0, glow = '0, cur = '0;
  logic vh = 1'b0, vl = 1'b0, ovo = 1'b0, uvo = 1'b0, olo = 1'b0, rd = 1'b0;
  logic [NCH-1:0] gate;
  logic fault_n;
  logic [SW-1:0] word;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  hss_fault_supervisor #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .logic_pwr_ok(pwr), .direct_in(din),
    .reg_on(ron), .over_temp(hot), .open_load(opn), .gate_low(glow),
    .over_curr(cur), .over_volt(vh), .under_volt(vl), .ovp_off(ovo),
    .uvp_off(uvo), .olp_off(olo), .rd_strobe(rd), .gate_en(gate),
    .fault_n(fault_n), .rd_word(word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_chk(input string tag, input logic [SW-1:0] exp);
    rd = 1'b1;
    #1;
    chk(tag, 32'(word), 32'(exp));
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic clear_word();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 gate", 32'(gate), 0);
    chk("R1 fault_n", 32'(fault_n), 1);
    read_chk("R1 word", '0);

    // R2 R4 R8 R10 exhaustive sweep on channel 0
    for (int p = 0; p < 256; p++) begin
      logic e_gate, e_open;
      {din[0], ron[0], vh, ovo, opn[0], olo, glow[0], uvo} = 8'(p);
      step(4);
      clear_word();
      step(1);
      e_gate = (din[0] | ron[0]) & !(vh & !ovo);
      e_open = opn[0] & !olo & glow[0] & !e_gate;
      chk("R2/R4 gate sweep", 32'(gate[0]), 32'(e_gate));
      chk("R10 fault_n sweep", 32'(fault_n), 32'(!(vh | e_open)));
      read_chk("R8/R4 word sweep", SW'((32'(e_open) << 1) | (32'(vh) << 6)));
    end
    {din, ron, vh, ovo, opn, olo, glow, uvo} = '0;
    step(4);
    clear_word();

    // R3 over-temperature cycle, repeated
    din[0] = 1'b1;
    step(3);
    for (int k = 0; k < 2; k++) begin
      hot[0] = 1'b1;
      step(1);
      chk("R3 gate off", 32'(gate[0]), 0);
      chk("R10 fault_n low ot", 32'(fault_n), 0);
      step(3);
      chk("R3 gate held off", 32'(gate[0]), 0);
      hot[0] = 1'b0;
      step(2);
      chk("R3 gate back", 32'(gate[0]), 1);
      chk("R10 fault_n released", 32'(fault_n), 1);
    end
    read_chk("R11 ot sticky bit0", SW'(1));
    read_chk("R11 cleared after read", '0);

    // R4 over-voltage enabled then disabled
    vh = 1'b1;
    step(1);
    chk("R4 gate off ov", 32'(gate[0]), 0);
    vh = 1'b0;
    step(1);
    chk("R4 gate recovers", 32'(gate[0]), 1);
    ovo = 1'b1; vh = 1'b1;
    step(3);
    chk("R4 disabled gate on", 32'(gate[0]), 1);
    chk("R4 warning fault_n", 32'(fault_n), 0);
    read_chk("R4 warning bit", SW'(1 << 6));
    vh = 1'b0; ovo = 1'b0;
    step(2);

    // R11 present fault re-sets after clear, transient does not
    vh = 1'b1; din[0] = 1'b0;
    step(2);
    read_chk("R11 read with ov", SW'(1 << 6));
    step(1);
    vh = 1'b0;
    step(1);
    read_chk("R11 re-set after clear", SW'(1 << 6));
    vh = 1'b1;
    step(2);
    clear_word();
    vh = 1'b0;
    step(1);
    read_chk("R11 transient not re-set", '0);
    step(2);

    // R5 latched under-voltage
    din[0] = 1'b1;
    step(3);
    vl = 1'b1;
    step(1);
    chk("R5 gate off uv", 32'(gate[0]), 0);
    vl = 1'b0;
    step(3);
    chk("R5 still latched", 32'(gate[0]), 0);
    chk("R5 fault_n latched", 32'(fault_n), 0);
    din[0] = 1'b0;
    step(2);
    din[0] = 1'b1;
    step(2);
    chk("R5 released by off-on", 32'(gate[0]), 1);
    chk("R5 fault_n released", 32'(fault_n), 1);
    clear_word();

    // R6 under-voltage with register command only
    din[0] = 1'b0; ron[0] = 1'b1;
    step(3);
    vl = 1'b1;
    step(1);
    chk("R6 gate off", 32'(gate[0]), 0);
    vl = 1'b0;
    step(2);
    chk("R6 not latched", 32'(gate[0]), 1);

    // R7 under-voltage protection disabled
    uvo = 1'b1; vl = 1'b1;
    step(3);
    chk("R7 no shutdown", 32'(gate[0]), 1);
    clear_word();
    step(1);
    read_chk("R7 warning bit", SW'(1 << 7));
    vl = 1'b0; uvo = 1'b0; ron[0] = 1'b0;
    step(3);
    clear_word();

    // R9 over-current latch, other channel unaffected
    din = 2'b11;
    step(3);
    cur[0] = 1'b1;
    step(1);
    chk("R9 gate off", 32'(gate[0]), 0);
    chk("R9 other channel on", 32'(gate[1]), 1);
    cur[0] = 1'b0;
    step(3);
    chk("R9 still latched", 32'(gate[0]), 0);
    chk("R9 fault_n latched", 32'(fault_n), 0);
    read_chk("R9 oc bit", SW'(1 << 2));
    din[0] = 1'b0;
    step(2);
    din[0] = 1'b1;
    step(2);
    chk("R9 released", 32'(gate[0]), 1);
    chk("R9 fault_n released", 32'(fault_n), 1);
    din = '0;
    step(2);
    clear_word();

    // R12 loss of logic supply
    pwr = 1'b0; ron[0] = 1'b1;
    step(2);
    chk("R12 reg_on ignored", 32'(gate[0]), 0);
    din[0] = 1'b1;
    step(2);
    chk("R12 direct drives", 32'(gate[0]), 1);
    ovo = 1'b1; vh = 1'b1;
    step(2);
    chk("R12 disable ignored", 32'(gate[0]), 0);
    read_chk("R12 word empty", '0);
    vh = 1'b0; ovo = 1'b0;
    step(2);
    pwr = 1'b1;
    step(1);
    read_chk("R12 cleared on return", '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule